// File: doc/BRIEF.md
# Phase-Gated Peripheral Memory Scheduler

This block decides when each of several peripheral bridges may move data to or from main memory. The CPU reports the phase of its running task through a small message port: a valid strobe with a 2-bit type. A predictable interval always runs a memory phase first, in which only the CPU touches memory, and then an execution phase, in which the CPU works from its cache and memory is free for peripherals. Outside an interval, the task runs unmodified code that may use memory at any time.

Each bridge raises its own request line and receives its own grant wire. The block grants memory to at most one bridge at a time, and only while the task is in its execution phase. Several requesting bridges share it round-robin. A holder keeps the grant until it drops its request or the phase ends. Because grants follow the phase the CPU reports, and not bus traffic, the CPU and the peripherals never contend for memory.

Top module: `phase_gate_sched`

## Requirements
- R1: After reset, `phase_o` reads 00 (no interval) and every grant is low.
- R2: With `msg_valid` high, type 01 moves the phase from 00 to the memory phase (`phase_o` = 01). Type 10 moves it from the memory phase to the execution phase (`phase_o` = 10). Type 11 moves it from either phase back to 00. Each change appears on `phase_o` one clock after the message.
- R3: A message of type 00, or one that does not follow the order above (01 inside an interval, 10 outside the memory phase, 11 outside an interval), leaves the phase and the grants unchanged.
- R4: No grant is high while `phase_o` is 00 or 01.
- R5: At most one grant bit is high in any cycle.
- R6: A grant goes only to a bridge whose request was high at the preceding clock edge. The first grant of an execution phase appears one clock after `phase_o` reads 10.
- R7: A free grant goes to the requesting bridge whose index follows, cyclically, the index of the last bridge granted. Bridge 0 is searched first after reset.
- R8: While the task stays in its execution phase and the holder keeps its request high, the grant stays with the holder, whatever the other bridges request.
- R9: When the holder drops its request, the grant passes at the same clock edge to the next requester in round-robin order, or to nobody if no bridge requests.
- R10: A type 11 message accepted in the execution phase clears every grant at the same clock edge at which `phase_o` returns to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | CPU message strobe |
| msg_type | input | 2 | Message type: 01 memory phase, 10 execution phase, 11 interval end |
| br_req | input | NUM_BRIDGES | Per-bridge memory request |
| br_grant | output | NUM_BRIDGES | Per-bridge dedicated grant wire |
| phase_o | output | 2 | Current phase: 00 none, 01 memory, 10 execution |

## Verification
If the phase register is corrupted, `phase_o` shows it one clock after the offending message. A wrong phase also shows as a grant that appears during the memory phase or is missing during the execution phase. If the round-robin pointer is wrong, the fault stays hidden until the next handoff, and then the wrong bridge's wire rises in the cycle after the holder releases. A stuck holder shows as a grant that outlives its request by a cycle, or that survives the end message.

// File: rtl/phase_gate_sched.sv
module phase_gate_sched #(
  parameter int NUM_BRIDGES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   msg_valid,
  input  logic [1:0]             msg_type,
  input  logic [NUM_BRIDGES-1:0] br_req,
  output logic [NUM_BRIDGES-1:0] br_grant,
  output logic [1:0]             phase_o
);
  localparam int IW = (NUM_BRIDGES > 1) ? $clog2(NUM_BRIDGES) : 1;
  localparam logic [1:0] PH_NONE = 2'b00;
  localparam logic [1:0] PH_MEM  = 2'b01;
  localparam logic [1:0] PH_EXEC = 2'b10;

  logic [1:0]             phase_q, phase_d;
  logic [NUM_BRIDGES-1:0] grant_q, grant_d;
  logic [IW-1:0]          last_q, pick;
  logic                   pick_ok, hold, stay_exec;

  always_comb begin
    phase_d = phase_q;
    if (msg_valid) begin
      case (msg_type)
        2'b01: if (phase_q == PH_NONE) phase_d = PH_MEM;
        2'b10: if (phase_q == PH_MEM)  phase_d = PH_EXEC;
        2'b11: if (phase_q != PH_NONE) phase_d = PH_NONE;
        default: phase_d = phase_q;
      endcase
    end
  end

  assign stay_exec = (phase_q == PH_EXEC) && (phase_d == PH_EXEC);
  assign hold      = |(grant_q & br_req);

  always_comb begin
    int idx;
    pick_ok = 1'b0;
    pick    = '0;
    for (int k = 1; k <= NUM_BRIDGES; k++) begin
      idx = (int'(last_q) + k) % NUM_BRIDGES;
      if (!pick_ok && br_req[idx]) begin
        pick_ok = 1'b1;
        pick    = IW'(idx);
      end
    end
  end

  always_comb begin
    grant_d = '0;
    if (stay_exec) begin
      if (hold)         grant_d = grant_q;
      else if (pick_ok) grant_d = NUM_BRIDGES'(1) << pick;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_NONE;
      grant_q <= '0;
      last_q  <= IW'(NUM_BRIDGES - 1);
    end else begin
      phase_q <= phase_d;
      grant_q <= grant_d;
      if (stay_exec && !hold && pick_ok) last_q <= pick;
    end
  end

  assign br_grant = grant_q;
  assign phase_o  = phase_q;
endmodule

module phase_gate_sched_chk #(
  parameter int NUM_BRIDGES = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   msg_valid,
  input logic [1:0]             msg_type,
  input logic [NUM_BRIDGES-1:0] br_req,
  input logic [NUM_BRIDGES-1:0] br_grant,
  input logic [1:0]             phase_o
);
  assert_one_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(br_grant));

  assert_no_grant_outside_exec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != 2'b10) |-> (br_grant == '0));

  assert_grant_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'b10) |=> ((br_grant & ~$past(br_req)) == '0));

  assert_end_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_type == 2'b11 && phase_o == 2'b10) |=> (br_grant == '0 && phase_o == 2'b00));

  assert_null_msg_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_valid || msg_type == 2'b00) |=> $stable(phase_o));

  assert_holder_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(br_grant & br_req)) && phase_o == 2'b10 && !(msg_valid && msg_type == 2'b11))
      |=> (br_grant == $past(br_grant)));
endmodule

bind phase_gate_sched phase_gate_sched_chk #(.NUM_BRIDGES(NUM_BRIDGES)) chk_i (.*);

// File: tb/phase_gate_sched_tb_top.sv
module phase_gate_sched_tb_top;
  localparam int N = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic msg_valid = 1'b0;
  logic [1:0] msg_type = 2'b00;
  logic [N-1:0] br_req = '0;
  logic [N-1:0] br_grant;
  logic [1:0] phase_o;
  int n_cmp = 0, n_bad = 0;
  logic [1:0] m_phase;
  logic [N-1:0] m_grant;
  int m_last;

  always #5 clk = ~clk;

  phase_gate_sched #(.NUM_BRIDGES(N)) dut_i (.*);

  function automatic logic [1:0] next_phase(logic [1:0] p, logic v, logic [1:0] t);
    if (!v) return p;
    if (t == 2'b01 && p == 2'b00) return 2'b01;
    if (t == 2'b10 && p == 2'b01) return 2'b10;
    if (t == 2'b11 && p != 2'b00) return 2'b00;
    return p;
  endfunction

  task automatic model_edge();
    logic [1:0] np;
    np = next_phase(m_phase, msg_valid, msg_type);
    if (!(m_phase == 2'b10 && np == 2'b10)) m_grant = '0;
    else if ((m_grant & br_req) == '0) begin
      m_grant = '0;
      for (int k = 1; k <= N; k++) begin
        int j;
        j = (m_last + k) % N;
        if (m_grant == '0 && br_req[j]) begin
          m_grant[j] = 1'b1;
          m_last = j;
        end
      end
    end
    m_phase = np;
  endtask

  task automatic compare(string tag);
    n_cmp++;
    if (phase_o !== m_phase) begin
      n_bad++;
      $display("FAIL %s phase actual=%b expected=%b", tag, phase_o, m_phase);
    end
    n_cmp++;
    if (br_grant !== m_grant) begin
      n_bad++;
      $display("FAIL %s grant actual=%b expected=%b", tag, br_grant, m_grant);
    end
    n_cmp++;
    if ($countones(br_grant) > 1) begin
      n_bad++;
      $display("FAIL R5 grants actual=%b expected=at most one", br_grant);
    end
  endtask

  task automatic step(logic v, logic [1:0] t, logic [N-1:0] r, string tag);
    msg_valid = v; msg_type = t; br_req = r;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'd2024);
    m_phase = 2'b00; m_grant = '0; m_last = N - 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1");
    step(1, 2'b10, 4'b1111, "R3");
    step(1, 2'b11, 4'b1111, "R3");
    step(1, 2'b00, 4'b1111, "R3");
    step(1, 2'b01, 4'b1111, "R2");
    step(0, 2'b00, 4'b1111, "R4");
    step(1, 2'b01, 4'b1111, "R3");
    step(1, 2'b10, 4'b1111, "R2");
    step(0, 2'b00, 4'b1111, "R6");
    step(0, 2'b00, 4'b1110, "R9");
    step(0, 2'b00, 4'b1110, "R8");
    step(1, 2'b00, 4'b0101, "R9");
    step(0, 2'b00, 4'b0001, "R7");
    step(1, 2'b10, 4'b0001, "R3");
    step(1, 2'b11, 4'b0001, "R10");
    step(0, 2'b00, 4'b1111, "R4");
    for (int i = 0; i < 4000; i++) begin
      logic v;
      logic [1:0] t;
      logic [N-1:0] r;
      v = ($urandom % 5) == 0;
      t = 2'($urandom);
      r = (($urandom % 3) == 0) ? N'($urandom) : br_req;
      step(v, t, r, "R7");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule